// File: doc/BRIEF.md
# Predicated Vector Floating-Point Comparator

This unit takes two packed vector operands and a governing predicate, compares the floating-point elements lane by lane, and produces a result predicate. The elements are half, single or double precision. A size input picks the precision. An operation code picks one of seven relations: greater-or-equal, greater-than, equal, not-equal, unordered, and the magnitude forms of greater-or-equal and greater-than. The predicates carry one bit for each byte of the vector. An element is governed by, and reports into, the bit of its lowest byte.

A request is presented with `req_valid`, and its result appears on the registered outputs one clock later. Lanes that are switched off by the predicate are not evaluated. Each relation uses either signalling or quiet treatment of NaNs. A sticky invalid-operation flag collects the exceptions raised by active lanes until software clears it. A request with a reserved size or a reserved operation code is rejected through `illegal`.

Top module: `fp_vec_cmp`

## Requirements
- R1: Size code 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit elements. A request with size code 0 sets `illegal` in the result cycle, returns an all-zero predicate and leaves the invalid flag unchanged.
- R2: The relation is chosen by {op_grp, op_x}. 010/0 is greater-or-equal and 010/1 is greater-than. 011/0 is equal and 011/1 is not-equal. 110/0 is unordered and 110/1 is magnitude greater-or-equal. 111/1 is magnitude greater-than. Every other combination is rejected as in R1.
- R3: Element k of an E-byte size occupies bytes kE to kE+E-1. Its result goes to predicate bit kE. Every other result bit is 0.
- R4: An element whose governing bit at its lowest byte is 0 returns 0 and contributes nothing to the invalid flag, even when it holds NaNs. Governing bits at the other bytes of an element are ignored.
- R5: Greater-or-equal and greater-than compute a >= b and a > b under IEEE ordering. +0 and -0 compare equal, and infinities are the extremes. Any NaN operand gives false and raises invalid.
- R6: Equal is false and not-equal is true when either operand is a NaN. Unordered is true exactly when at least one operand is a NaN. These three relations raise invalid only for a signalling NaN.
- R7: The magnitude relations clear both sign bits and then compare as in R5, including false and invalid for any NaN.
- R8: `invalid_flag` is the OR of the invalid results of all active lanes of legal requests. It stays set until `flag_clr` is asserted. A clear in the same cycle as a request leaves only that request's contribution.
- R9: Outputs are registered. `res_valid` is high exactly one cycle after `req_valid`. With no request, the predicate and `illegal` are 0.
- R10: A NaN has an all-ones exponent and a nonzero fraction. It is quiet when the top fraction bit is 1 and signalling otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| esz | input | 2 | Element size code |
| op_grp | input | 3 | Operation group code |
| op_x | input | 1 | Operation qualifier bit |
| vec_a | input | VW | First operand vector |
| vec_b | input | VW | Second operand vector |
| pred_g | input | VW/8 | Governing predicate, one bit per byte |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_pred | output | VW/8 | Result predicate |
| illegal | output | 1 | Request had a reserved size or operation code |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench sweeps every pair from a set of corner operands in each precision and each relation: signed zeros, ones, a denormal, the largest normal, both infinities, and quiet and signalling NaNs of both signs. It adds random operands and random predicates. A design that honoured the sign on zero would report +0 > -0. A design that treated quiet NaNs as signalling in the equal and unordered relations would raise the flag on every quiet NaN. A design that evaluated switched-off lanes would set the flag from a NaN in an inactive lane. A design that put the result on the wrong byte bit would break the lead-bit pattern. The bench also checks rejected size and operation codes, flag persistence across quiet requests, and the ordering when a clear and a request arrive together.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    typedef enum logic [2:0] {
        CMP_GE  = 3'd0,
        CMP_GT  = 3'd1,
        CMP_EQ  = 3'd2,
        CMP_NE  = 3'd3,
        CMP_UO  = 3'd4,
        CMP_AGE = 3'd5,
        CMP_AGT = 3'd6
    } cmp_op_e;
endpackage

// File: rtl/fp_cmp_decode.sv
module fp_cmp_decode
    import fpcmp_pkg::*;
(
    input  logic [2:0] op_grp,
    input  logic       op_x,
    output cmp_op_e    op,
    output logic       legal
);
    always_comb begin
        op    = CMP_GE;
        legal = 1'b1;
        unique case ({op_grp, op_x})
            4'b010_0: op = CMP_GE;
            4'b010_1: op = CMP_GT;
            4'b011_0: op = CMP_EQ;
            4'b011_1: op = CMP_NE;
            4'b110_0: op = CMP_UO;
            4'b110_1: op = CMP_AGE;
            4'b111_1: op = CMP_AGT;
            default:  legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_lane_cmp.sv
module fp_lane_cmp
    import fpcmp_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic          en,
    input  cmp_op_e       op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic          hit,
    output logic          inv
);
    localparam int EXPW = (EW == 16) ? 5 : (EW == 32) ? 8 : 11;
    localparam int FRW  = EW - 1 - EXPW;

    logic          use_abs;
    logic          sa, sb;
    logic [EW-2:0] ma, mb;
    logic          a_nan, b_nan, a_snan, b_snan;
    logic          unord, any_snan, zz, eq, gt;

    always_comb begin
        use_abs  = (op == CMP_AGE) || (op == CMP_AGT);
        sa       = a[EW-1] & ~use_abs;
        sb       = b[EW-1] & ~use_abs;
        ma       = a[EW-2:0];
        mb       = b[EW-2:0];
        a_nan    = (&ma[EW-2:FRW]) && (|ma[FRW-1:0]);
        b_nan    = (&mb[EW-2:FRW]) && (|mb[FRW-1:0]);
        a_snan   = a_nan && !ma[FRW-1];
        b_snan   = b_nan && !mb[FRW-1];
        unord    = a_nan || b_nan;
        any_snan = a_snan || b_snan;
        zz       = (ma == '0) && (mb == '0);
        eq       = zz || ((sa == sb) && (ma == mb));
        gt       = !zz && ((!sa && sb) ||
                           (!sa && !sb && (ma > mb)) ||
                           (sa && sb && (ma < mb)));
        hit = 1'b0;
        inv = 1'b0;
        unique case (op)
            CMP_GE, CMP_AGE: begin hit = !unord && (gt || eq); inv = unord; end
            CMP_GT, CMP_AGT: begin hit = !unord && gt;         inv = unord; end
            CMP_EQ:          begin hit = !unord && eq;         inv = any_snan; end
            CMP_NE:          begin hit = unord || !eq;         inv = any_snan; end
            CMP_UO:          begin hit = unord;                inv = any_snan; end
            default:         begin hit = 1'b0;                 inv = 1'b0; end
        endcase
        if (!en) begin
            hit = 1'b0;
            inv = 1'b0;
        end
    end
endmodule

// File: rtl/fp_vec_cmp.sv
module fp_vec_cmp
    import fpcmp_pkg::*;
#(
    parameter int VW = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      esz,
    input  logic [2:0]      op_grp,
    input  logic            op_x,
    input  logic [VW-1:0]   vec_a,
    input  logic [VW-1:0]   vec_b,
    input  logic [VW/8-1:0] pred_g,
    input  logic            flag_clr,
    output logic            res_valid,
    output logic [VW/8-1:0] res_pred,
    output logic            illegal,
    output logic            invalid_flag
);
    localparam int NB = VW / 8;
    localparam int NSZ = 3;

    typedef struct packed {
        logic [NB-1:0] res;
        logic          vld;
        logic          ill;
        logic          flg;
    } state_t;

    state_t state_d, state_q;

    cmp_op_e op;
    logic    op_ok;
    logic    legal;

    logic [NSZ-1:0][NB-1:0] hit_sz;
    logic [NSZ-1:0]         inv_sz;

    fp_cmp_decode u_dec (
        .op_grp (op_grp),
        .op_x   (op_x),
        .op     (op),
        .legal  (op_ok)
    );

    assign legal = op_ok && (esz != 2'd0);

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        localparam int EW = 16 << g;
        localparam int EB = EW / 8;
        localparam int NL = VW / EW;
        logic [NB-1:0] hp;
        logic [NL-1:0] iv;
        logic          sz_on;
        assign sz_on = req_valid && legal && (esz == 2'(g + 1));
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic lh;
            fp_lane_cmp #(.EW(EW)) u_lane (
                .en  (sz_on && pred_g[l*EB]),
                .op  (op),
                .a   (vec_a[l*EW +: EW]),
                .b   (vec_b[l*EW +: EW]),
                .hit (lh),
                .inv (iv[l])
            );
            assign hp[l*EB +: EB] = {{(EB-1){1'b0}}, lh};
        end
        assign hit_sz[g] = hp;
        assign inv_sz[g] = |iv;
    end

    always_comb begin
        state_d     = '0;
        state_d.vld = req_valid;
        state_d.ill = req_valid && !legal;
        if (req_valid && legal) begin
            unique case (esz)
                2'd1:    state_d.res = hit_sz[0];
                2'd2:    state_d.res = hit_sz[1];
                default: state_d.res = hit_sz[2];
            endcase
        end
        state_d.flg = (flag_clr ? 1'b0 : state_q.flg) | (|inv_sz);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid    = state_q.vld;
    assign res_pred     = state_q.res;
    assign illegal      = state_q.ill;
    assign invalid_flag = state_q.flg;
endmodule

// File: rtl/fp_vec_cmp_chk.sv
module fp_vec_cmp_chk #(
    parameter int VW = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      esz,
    input logic [VW/8-1:0] pred_g,
    input logic            flag_clr,
    input logic            res_valid,
    input logic [VW/8-1:0] res_pred,
    input logic            illegal,
    input logic            invalid_flag
);
    localparam int NB = VW / 8;

    logic [1:0]    esz_q;
    logic [NB-1:0] pred_q;
    logic [NB-1:0] lead_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esz_q  <= '0;
            pred_q <= '0;
        end else begin
            esz_q  <= esz;
            pred_q <= pred_g;
        end
    end

    always_comb begin
        for (int i = 0; i < NB; i++)
            lead_mask[i] = ((i % (1 << esz_q)) == 0);
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && res_pred == '0 && !illegal));
    a_r3_lead_only: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_pred & ~lead_mask) == '0));
    a_r4_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_pred & ~pred_q) == '0));
    a_r1_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && esz == 2'd0) |=> (illegal && res_pred == '0));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !flag_clr) |=> invalid_flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !req_valid) |=> !invalid_flag);
endmodule

bind fp_vec_cmp fp_vec_cmp_chk #(.VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .esz          (esz),
    .pred_g       (pred_g),
    .flag_clr     (flag_clr),
    .res_valid    (res_valid),
    .res_pred     (res_pred),
    .illegal      (illegal),
    .invalid_flag (invalid_flag)
);

// File: tb/fp_vec_cmp_test.sv
module fp_vec_cmp_test;
    localparam int VW = 64;
    localparam int NB = VW / 8;
    localparam int NC = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    esz = 2'd1;
    logic [2:0]    op_grp = 3'b010;
    logic          op_x = 1'b0;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [NB-1:0] pred_g = '0;
    logic          flag_clr = 1'b0;
    logic          res_valid;
    logic [NB-1:0] res_pred;
    logic          illegal;
    logic          invalid_flag;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fp_vec_cmp #(.VW(VW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .esz(esz),
        .op_grp(op_grp), .op_x(op_x), .vec_a(vec_a), .vec_b(vec_b),
        .pred_g(pred_g), .flag_clr(flag_clr), .res_valid(res_valid),
        .res_pred(res_pred), .illegal(illegal), .invalid_flag(invalid_flag)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] op_code(int op);
        case (op)
            0: return 4'b010_0;
            1: return 4'b010_1;
            2: return 4'b011_0;
            3: return 4'b011_1;
            4: return 4'b110_0;
            5: return 4'b110_1;
            default: return 4'b111_1;
        endcase
    endfunction

    function automatic int expw_of(int ew);
        return (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    endfunction

    function automatic logic [63:0] corner(int ew, int idx);
        int expw = expw_of(ew);
        int frw = ew - 1 - expw;
        logic [63:0] sgn = 64'd1 << (ew - 1);
        logic [63:0] emax = (64'd1 << expw) - 64'd1;
        logic [63:0] bias = (64'd1 << (expw - 1)) - 64'd1;
        logic [63:0] fmax = (64'd1 << frw) - 64'd1;
        case (idx)
            0:  return 64'd0;
            1:  return sgn;
            2:  return bias << frw;
            3:  return sgn | (bias << frw);
            4:  return (bias + 64'd1) << frw;
            5:  return 64'd1;
            6:  return sgn | 64'd1;
            7:  return ((emax - 64'd1) << frw) | fmax;
            8:  return emax << frw;
            9:  return sgn | (emax << frw);
            10: return (emax << frw) | (64'd1 << (frw - 1));
            11: return sgn | (emax << frw) | (64'd1 << (frw - 1));
            12: return (emax << frw) | 64'd1;
            default: return sgn | (emax << frw) | 64'd3;
        endcase
    endfunction

    // Independent model: returns {invalid, result}
    function automatic logic [1:0] ref_lane(int ew, logic [63:0] a, logic [63:0] b, int op);
        int expw = expw_of(ew);
        int frw = ew - 1 - expw;
        logic [63:0] mmask = (64'd1 << (ew - 1)) - 64'd1;
        logic [63:0] emax = (64'd1 << expw) - 64'd1;
        logic [63:0] fmask = (64'd1 << frw) - 64'd1;
        logic [63:0] ma = a & mmask;
        logic [63:0] mb = b & mmask;
        logic sa = a[ew-1];
        logic sb = b[ew-1];
        logic na = ((ma >> frw) == emax) && ((ma & fmask) != 0);
        logic nb = ((mb >> frw) == emax) && ((mb & fmask) != 0);
        logic qa = ma[frw-1];
        logic qb = mb[frw-1];
        logic unord = na || nb;
        logic sn = (na && !qa) || (nb && !qb);
        logic signed [65:0] ka, kb;
        if (op >= 5) begin sa = 1'b0; sb = 1'b0; end
        ka = sa ? -$signed({2'b00, ma}) : $signed({2'b00, ma});
        kb = sb ? -$signed({2'b00, mb}) : $signed({2'b00, mb});
        case (op)
            0, 5: return {unord, !unord && (ka >= kb)};
            1, 6: return {unord, !unord && (ka > kb)};
            2:    return {sn, !unord && (ka == kb)};
            3:    return {sn, unord || (ka != kb)};
            default: return {sn, unord};
        endcase
    endfunction

    // Issue one request, sample result in the following cycle.
    task automatic issue(logic [1:0] sz, logic [3:0] code, logic [VW-1:0] a,
                         logic [VW-1:0] b, logic [NB-1:0] p, logic clr);
        @(negedge clk);
        req_valid = 1'b1; esz = sz; op_grp = code[3:1]; op_x = code[0];
        vec_a = a; vec_b = b; pred_g = p; flag_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; flag_clr = 1'b0;
    endtask

    function automatic string op_req(int op);
        return (op <= 1) ? "R5" : (op <= 4) ? "R6" : "R7";
    endfunction

    task automatic run_vec(int sz, int op, logic [VW-1:0] a, logic [VW-1:0] b,
                           logic [NB-1:0] p);
        int ew = 8 << sz;
        int eb = ew / 8;
        logic [NB-1:0] ep = '0;
        logic einv = 1'b0;
        for (int l = 0; l < VW / ew; l++) begin
            logic [1:0] r;
            if (p[l*eb]) begin
                r = ref_lane(ew, (a >> (l*ew)) & ((ew == 64) ? ~64'd0 : ((64'd1 << ew) - 64'd1)),
                                 (b >> (l*ew)) & ((ew == 64) ? ~64'd0 : ((64'd1 << ew) - 64'd1)), op);
                ep[l*eb] = r[0];
                einv = einv | r[1];
            end
        end
        issue(2'(sz), op_code(op), a, b, p, 1'b1);
        check({op_req(op), " R3 result predicate"}, 64'(res_pred), 64'(ep));
        check("R8 flag from active lanes", 64'(invalid_flag), 64'(einv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", 64'(res_valid), 64'd0);
        check("R9 reset pred", 64'(res_pred), 64'd0);
        check("R8 reset flag", 64'(invalid_flag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Corner sweep: all pairs, all relations, all sizes
        for (int sz = 1; sz <= 3; sz++) begin
            int ew = 8 << sz;
            int nl = VW / ew;
            for (int op = 0; op < 7; op++) begin
                for (int p = 0; p < NC * NC; p += nl) begin
                    logic [VW-1:0] a = '0;
                    logic [VW-1:0] b = '0;
                    for (int l = 0; l < nl; l++) begin
                        int k = (p + l) % (NC * NC);
                        a = a | (VW'(corner(ew, k / NC)) << (l * ew));
                        b = b | (VW'(corner(ew, k % NC)) << (l * ew));
                    end
                    run_vec(sz, op, a, b, NB'($urandom) | NB'(1));
                end
            end
        end

        // Random operands and predicates (R4 inactive lanes included)
        for (int n = 0; n < 300; n++) begin
            int sz = 1 + (n % 3);
            int op = (n / 3) % 7;
            logic [VW-1:0] a = {$urandom, $urandom};
            logic [VW-1:0] b = (n % 5 == 0) ? a : {$urandom, $urandom};
            run_vec(sz, op, a, b, NB'($urandom));
        end

        // R3: equal values, all governing bits set: lead bits only
        issue(2'd1, op_code(0), '0, '0, '1, 1'b1);
        check("R3 half lead bits", 64'(res_pred), 64'h55);
        issue(2'd2, op_code(0), '0, '0, '1, 1'b1);
        check("R3 single lead bits", 64'(res_pred), 64'h11);
        issue(2'd3, op_code(0), '0, '0, '1, 1'b1);
        check("R3 double lead bits", 64'(res_pred), 64'h01);

        // R4: NaNs in lanes governed only by non-lead bits
        issue(2'd1, op_code(0), {4{corner(16, 12)[15:0]}}, {4{corner(16, 12)[15:0]}}, 8'hAA, 1'b1);
        check("R4 inactive NaN pred", 64'(res_pred), 64'd0);
        check("R4 inactive NaN flag", 64'(invalid_flag), 64'd0);

        // R10 / R6: quiet NaN is silent for equal, signalling NaN raises
        issue(2'd2, op_code(2), {2{corner(32, 10)[31:0]}}, '0, '1, 1'b1);
        check("R10 quiet NaN no flag", 64'(invalid_flag), 64'd0);
        issue(2'd2, op_code(2), {2{corner(32, 12)[31:0]}}, '0, '1, 1'b1);
        check("R10 signalling NaN flag", 64'(invalid_flag), 64'd1);

        // R8: sticky across a clean request, cleared by clear alone
        issue(2'd3, op_code(0), '0, '0, '1, 1'b0);
        check("R8 sticky", 64'(invalid_flag), 64'd1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R8 clear", 64'(invalid_flag), 64'd0);
        check("R9 idle valid", 64'(res_valid), 64'd0);
        check("R9 idle pred", 64'(res_pred), 64'd0);

        // R1: size code 0 rejected, flag untouched
        issue(2'd0, op_code(0), '1, '1, '1, 1'b0);
        check("R1 illegal", 64'(illegal), 64'd1);
        check("R1 pred zero", 64'(res_pred), 64'd0);
        check("R1 flag untouched", 64'(invalid_flag), 64'd0);

        // R2: reserved operation codes
        issue(2'd1, 4'b111_0, '1, '1, '1, 1'b0);
        check("R2 reserved 111/0", 64'(illegal), 64'd1);
        check("R2 reserved pred", 64'(res_pred), 64'd0);
        issue(2'd1, 4'b000_1, '1, '1, '1, 1'b0);
        check("R2 reserved 000/1", 64'(illegal), 64'd1);
        issue(2'd1, op_code(6), '0, '0, '1, 1'b0);
        check("R2 legal code", 64'(illegal), 64'd0);
        check("R9 valid", 64'(res_valid), 64'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule